// File: doc/BRIEF.md
# Iterative Effective Address Generator

This block resolves the final operand address of an instruction for a machine with 36-bit words and an 18-bit word address. It accepts three instruction fields: an indirect flag, a 4-bit index register number and an 18-bit displacement. If the index number is nonzero, the low half of that general register is added to the displacement. If the indirect flag is set, the word at the resulting address is fetched and its low 23 bits supply a fresh indirect flag, index number and displacement. This repeats until a step finds the indirect flag clear. The address from that step is the effective address.

The 16 general registers also occupy word addresses 0 to 15. An indirect fetch that lands in that range is served from the register file read port and never reaches memory. All other fetches go out on a valid/ready read request port, and at most one read is in flight at a time. The result is reported with a one-cycle strobe and is held until the next walk is accepted. Since a chain of indirect words that points at itself never ends, an abort input lets the surrounding control stop a walk.

Top module: `eff_addr_walker`

## Requirements
- R1: When a walk has the indirect flag clear and index number 0, `ea_out` equals the displacement and `ea_done` is high in the cycle after the first rising edge that follows the edge which sampled `start`.
- R2: A nonzero index number X adds bits [17:0] of register X to the displacement modulo 2^18. The carry out is dropped and register bits [35:18] have no effect.
- R3: Index number 0 applies no indexing, even when register 0 holds a nonzero value.
- R4: With the indirect flag set, the word at the computed address is decoded as indirect flag = bit [22], index number = bits [21:18], displacement = bits [17:0], and the calculation repeats. Bits [35:23] of a fetched word have no effect.
- R5: A computed indirect address below 16 is read from register `rf_addr` of the register file in one extra cycle, and no memory request is issued for it.
- R6: A memory request holds `req_addr` stable while `req_valid` is high and `req_ready` low. `req_valid` drops after acceptance, so only one read is ever outstanding.
- R7: Each memory step adds 3 cycles plus the cycles `req_ready` is held low. Each register step adds 2 cycles to the R1 latency.
- R8: `ea_done` is high for exactly one cycle per walk, and `ea_out` keeps its value until a later walk completes.
- R9: `abort` during a walk returns the block to idle on the next edge without an `ea_done` pulse.
- R10: `start` while a walk is in progress is ignored and does not change that walk's result.
- R11: Reset leaves `busy`, `ea_done` and `req_valid` low and `ea_out` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk with the instruction fields below |
| instr_ind | input | 1 | Indirect flag of the instruction |
| instr_xr | input | 4 | Index register number of the instruction |
| instr_y | input | 18 | Displacement of the instruction |
| abort | input | 1 | Abandon the walk in progress |
| rf_addr | output | 4 | Register file read address |
| rf_data | input | 36 | Register file read data (combinational) |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory read request accepted |
| req_addr | output | 18 | Memory read word address |
| rsp_valid | input | 1 | Memory read data valid |
| rsp_data | input | 36 | Memory read data |
| busy | output | 1 | A walk is in progress |
| ea_done | output | 1 | One-cycle strobe: effective address ready |
| ea_out | output | 18 | Effective address, held until the next result |

## Verification
The done strobe is due 1 + 2r + (3 + s)m edges after the edge that samples `start`. Here r is the number of register-aliased steps, m the number of memory steps and s the number of stall cycles per request. The bench works out r, m and the address from its own copy of the register file and memory, so it knows in advance the cycle in which `ea_done` must appear. On every falling edge of a walk, it compares `ea_done` against that single expected cycle and checks `ea_out` in it. After each walk it also compares the number of memory requests with m, which shows that register-aliased fetches never reach the memory port.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int WORD_W  = 36;
    localparam int ADDR_W  = 18;
    localparam int XREG_W  = 4;
    localparam int NREG    = 1 << XREG_W;
    localparam int FIELD_W = ADDR_W + XREG_W + 1;

    typedef struct packed {
        logic              ind;
        logic [XREG_W-1:0] xr;
        logic [ADDR_W-1:0] y;
    } ea_fields_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_REGRD,
        ST_MREQ,
        ST_MWAIT
    } walk_state_t;

    // Low part of a word: indirect flag above index number above displacement.
    function automatic ea_fields_t unpack_word(input logic [FIELD_W-1:0] w);
        ea_fields_t f;
        f.ind = w[FIELD_W-1];
        f.xr  = w[ADDR_W +: XREG_W];
        f.y   = w[ADDR_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/ea_index_unit.sv
module ea_index_unit #(
    parameter int ADDR_W = ea_pkg::ADDR_W,
    parameter int XREG_W = ea_pkg::XREG_W
) (
    input  logic [XREG_W-1:0] xr,
    input  logic [ADDR_W-1:0] disp,
    input  logic [ADDR_W-1:0] xval,
    output logic [ADDR_W-1:0] sum
);
    logic [ADDR_W-1:0] addend;

    always_comb begin
        addend = (xr != '0) ? xval : '0;
        sum    = disp + addend;
    end
endmodule

// File: rtl/ea_alias_check.sv
module ea_alias_check #(
    parameter int ADDR_W = ea_pkg::ADDR_W,
    parameter int XREG_W = ea_pkg::XREG_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_reg
);
    generate
        if (ADDR_W > XREG_W) begin : g_cmp
            assign is_reg = (addr[ADDR_W-1:XREG_W] == '0);
        end else begin : g_all
            assign is_reg = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/ea_walk_fsm.sv
module ea_walk_fsm #(
    parameter int ADDR_W  = ea_pkg::ADDR_W,
    parameter int XREG_W  = ea_pkg::XREG_W,
    localparam int FIELD_W = ADDR_W + XREG_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  ea_pkg::ea_fields_t start_f,
    input  logic               abort,
    input  logic [ADDR_W-1:0]  sum,
    input  logic               sum_is_reg,
    input  logic [FIELD_W-1:0] rf_low,
    input  logic               req_ready,
    input  logic               rsp_valid,
    input  logic [FIELD_W-1:0] rsp_low,
    output ea_pkg::ea_fields_t cur,
    output logic [XREG_W-1:0]  rf_sel,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  ea
);
    import ea_pkg::*;

    walk_state_t       st;
    logic [ADDR_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cur  <= '0;
            ptr  <= '0;
            done <= 1'b0;
            ea   <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        cur <= start_f;
                        st  <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    if (abort) begin
                        st <= ST_IDLE;
                    end else if (!cur.ind) begin
                        ea   <= sum;
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end else begin
                        ptr <= sum;
                        st  <= sum_is_reg ? ST_REGRD : ST_MREQ;
                    end
                end
                ST_REGRD: begin
                    if (abort) begin
                        st <= ST_IDLE;
                    end else begin
                        cur <= unpack_word(rf_low);
                        st  <= ST_CALC;
                    end
                end
                ST_MREQ: begin
                    if (abort)          st <= ST_IDLE;
                    else if (req_ready) st <= ST_MWAIT;
                end
                ST_MWAIT: begin
                    if (abort) begin
                        st <= ST_IDLE;
                    end else if (rsp_valid) begin
                        cur <= unpack_word(rsp_low);
                        st  <= ST_CALC;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rf_sel    = (st == ST_REGRD) ? ptr[XREG_W-1:0] : cur.xr;
        req_valid = (st == ST_MREQ);
        req_addr  = ptr;
        busy      = (st != ST_IDLE);
    end
endmodule

// File: rtl/eff_addr_walker.sv
module eff_addr_walker #(
    parameter int WORD_W = ea_pkg::WORD_W,
    parameter int ADDR_W = ea_pkg::ADDR_W,
    parameter int XREG_W = ea_pkg::XREG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              instr_ind,
    input  logic [XREG_W-1:0] instr_xr,
    input  logic [ADDR_W-1:0] instr_y,
    input  logic              abort,
    output logic [XREG_W-1:0] rf_addr,
    input  logic [WORD_W-1:0] rf_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_data,
    output logic              busy,
    output logic              ea_done,
    output logic [ADDR_W-1:0] ea_out
);
    localparam int FIELD_W = ADDR_W + XREG_W + 1;

    ea_pkg::ea_fields_t start_f;
    ea_pkg::ea_fields_t cur;
    logic [ADDR_W-1:0]  sum;
    logic               sum_is_reg;
    logic               unused_hi;

    assign start_f   = '{ind: instr_ind, xr: instr_xr, y: instr_y};
    assign unused_hi = ^{rf_data[WORD_W-1:FIELD_W], rsp_data[WORD_W-1:FIELD_W]};

    ea_index_unit #(.ADDR_W(ADDR_W), .XREG_W(XREG_W)) u_index (
        .xr   (cur.xr),
        .disp (cur.y),
        .xval (rf_data[ADDR_W-1:0]),
        .sum  (sum)
    );

    ea_alias_check #(.ADDR_W(ADDR_W), .XREG_W(XREG_W)) u_alias (
        .addr   (sum),
        .is_reg (sum_is_reg)
    );

    ea_walk_fsm #(.ADDR_W(ADDR_W), .XREG_W(XREG_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_f    (start_f),
        .abort      (abort),
        .sum        (sum),
        .sum_is_reg (sum_is_reg),
        .rf_low     (rf_data[FIELD_W-1:0]),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_low    (rsp_data[FIELD_W-1:0]),
        .cur        (cur),
        .rf_sel     (rf_addr),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .busy       (busy),
        .done       (ea_done),
        .ea         (ea_out)
    );
endmodule

// File: rtl/ea_walker_chk.sv
module ea_walker_chk #(
    parameter int ADDR_W = ea_pkg::ADDR_W,
    parameter int NREG   = ea_pkg::NREG
) (
    input logic              clk,
    input logic              rst,
    input logic              abort,
    input logic              busy,
    input logic              ea_done,
    input logic [ADDR_W-1:0] ea_out,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr
);
    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (!busy && !ea_done && !req_valid));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        ea_done |=> !ea_done);

    assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(ea_out));

    assert_req_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !abort) |=> (req_valid && $stable(req_addr)));

    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_valid);

    assert_no_mem_for_regs_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr >= NREG));

    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && abort) |=> (!busy && !ea_done));
endmodule

bind eff_addr_walker ea_walker_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .abort     (abort),
    .busy      (busy),
    .ea_done   (ea_done),
    .ea_out    (ea_out),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr)
);

// File: tb/eff_addr_walker_test.sv
module eff_addr_walker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        instr_ind = 1'b0;
    logic [3:0]  instr_xr = '0;
    logic [17:0] instr_y = '0;
    logic        abort = 1'b0;
    logic [3:0]  rf_addr;
    logic [35:0] rf_data;
    logic        req_valid;
    logic        req_ready;
    logic [17:0] req_addr;
    logic        rsp_valid = 1'b0;
    logic [35:0] rsp_data = '0;
    logic        busy;
    logic        ea_done;
    logic [17:0] ea_out;

    logic [35:0] rf [16];
    logic [35:0] mem [logic [17:0]];
    int stall_n = 0;
    int wcnt = 0;
    int nreq = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eff_addr_walker uut (
        .clk(clk), .rst(rst), .start(start), .instr_ind(instr_ind),
        .instr_xr(instr_xr), .instr_y(instr_y), .abort(abort),
        .rf_addr(rf_addr), .rf_data(rf_data), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .busy(busy), .ea_done(ea_done), .ea_out(ea_out)
    );

    assign rf_data   = rf[rf_addr];
    assign req_ready = (wcnt >= stall_n);

    // Memory responder: answers one cycle after acceptance.
    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        if (req_valid && !req_ready) wcnt <= wcnt + 1;
        if (req_valid && req_ready) begin
            wcnt      <= 0;
            rsp_valid <= 1'b1;
            rsp_data  <= mem.exists(req_addr) ? mem[req_addr] : 36'h0;
            nreq      <= nreq + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] fetch(input logic [17:0] a);
        if (a < 18'd16) return rf[a[3:0]];
        return mem.exists(a) ? mem[a] : 36'h0;
    endfunction

    // Behavioural model: expected address and step counts.
    task automatic model(input logic i, input logic [3:0] x, input logic [17:0] y,
                         output logic [17:0] ea, output int m, output int r);
        logic        ci = i;
        logic [3:0]  cx = x;
        logic [17:0] cy = y;
        logic [17:0] a;
        logic [35:0] w;
        bit          fin = 0;
        m = 0; r = 0; ea = '0;
        for (int s = 0; s < 64 && !fin; s++) begin
            a = cy + ((cx != 4'd0) ? rf[cx][17:0] : 18'd0);
            if (!ci) begin
                ea  = a;
                fin = 1;
            end else begin
                if (a < 18'd16) r++; else m++;
                w  = fetch(a);
                ci = w[22];
                cx = w[21:18];
                cy = w[17:0];
            end
        end
    endtask

    task automatic run_walk(input string tag, input logic i, input logic [3:0] x,
                            input logic [17:0] y, input int stall, input bit poke);
        logic [17:0] exp_ea;
        int m, r, exp_k, n0;
        model(i, x, y, exp_ea, m, r);
        stall_n = stall;
        exp_k = 1 + (3 + stall) * m + 2 * r;
        n0 = nreq;
        @(negedge clk);
        start = 1'b1; instr_ind = i; instr_xr = x; instr_y = y;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= exp_k + 3; k++) begin
            if (poke && k == 2) begin
                start = 1'b1; instr_ind = 1'b0; instr_xr = 4'd0; instr_y = 18'h33333;
            end
            @(negedge clk);
            start = 1'b0;
            chk(ea_done == (k == exp_k), {tag, " done timing R7"}, 36'(ea_done), 36'(k == exp_k));
            if (k == exp_k) chk(ea_out == exp_ea, {tag, " address"}, 36'(ea_out), 36'(exp_ea));
        end
        chk(ea_out == exp_ea, {tag, " held R8"}, 36'(ea_out), 36'(exp_ea));
        chk(busy == 1'b0, {tag, " idle after R8"}, 36'(busy), 36'h0);
        chk((nreq - n0) == m, {tag, " memory reads R5"}, 36'(nreq - n0), 36'(m));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) rf[k] = 36'h0;
        rf[0]  = 36'h000000777;
        rf[3]  = 36'hFFFF00100;
        rf[5]  = 36'hFFF03FFF0;
        rf[7]  = {13'h1ABC, 1'b0, 4'd3, 18'h00020};
        rf[15] = {13'h0, 1'b0, 4'd0, 18'h2ABCD};
        mem[18'h100] = {13'h1FFF, 1'b0, 4'd3, 18'h00050};
        mem[18'h500] = {13'h0, 1'b1, 4'd0, 18'h00600};
        mem[18'h600] = {13'h1555, 1'b1, 4'd5, 18'h0001F};
        mem[18'h200] = {13'h0, 1'b1, 4'd0, 18'h00200};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(busy == 1'b0, "R11 busy", 36'(busy), 36'h0);
        chk(ea_done == 1'b0, "R11 done", 36'(ea_done), 36'h0);
        chk(req_valid == 1'b0, "R11 req_valid", 36'(req_valid), 36'h0);
        chk(ea_out == 18'h0, "R11 ea_out", 36'(ea_out), 36'h0);

        run_walk("R1 direct", 1'b0, 4'd0, 18'h01234, 0, 0);
        run_walk("R2 index wrap", 1'b0, 4'd5, 18'h00020, 0, 0);
        run_walk("R3 reg0 no index", 1'b0, 4'd0, 18'h00042, 0, 0);
        run_walk("R4 mem indirect", 1'b1, 4'd0, 18'h00100, 0, 0);
        run_walk("R5 reg alias", 1'b1, 4'd0, 18'h00007, 0, 0);
        run_walk("R6 R7 chain stall", 1'b1, 4'd3, 18'h00400, 2, 0);
        run_walk("R10 start ignored", 1'b1, 4'd3, 18'h00400, 1, 1);

        // R9: abort a self-referencing chain
        stall_n = 0;
        @(negedge clk);
        start = 1'b1; instr_ind = 1'b1; instr_xr = 4'd0; instr_y = 18'h00200;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(ea_done == 1'b0, "R9 no done in loop", 36'(ea_done), 36'h0);
        end
        chk(busy == 1'b1, "R9 busy in loop", 36'(busy), 36'h1);
        while (req_valid || rsp_valid) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(busy == 1'b0, "R9 idle after abort", 36'(busy), 36'h0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(ea_done == 1'b0 && req_valid == 1'b0, "R9 quiet after abort",
                36'({ea_done, req_valid}), 36'h0);
        end
        chk(ea_out == 18'h2ABCD, "R9 R8 result kept", 36'(ea_out), 36'h2ABCD);

        run_walk("R1 after abort", 1'b0, 4'd0, 18'h3FFFF, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule